// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the 13-bit fetch address of a small controller core whose fetch and execute stages overlap by one instruction cycle. At every instruction-cycle boundary, marked by a clock enable, it chooses the next address. The candidates are, in order of precedence:

- a pending interrupt's fixed vector,
- a return address from an external stack,
- a full jump or call target,
- a write of the low address byte, which jumps within the current 256-word page,
- a skip that advances by two,
- the plain increment.

After any non-sequential choice it raises a flush flag for one instruction cycle. The flag tells the core to replace the word that was already prefetched with a dummy cycle.

The instruction decoder drives the strobes and samples the flush flag. On interrupt entry, an external stack takes the address of the next unexecuted instruction from a dedicated output. The low byte of the counter is always available for readback.

Top module: `pc_sequencer`

## Requirements
- R1: While rstN is low, fetchAddr is 0x0000, flush is 0 and lowRead is 0x00.
- R2: fetchAddr and flush change only on a clock edge where cycleEn is 1. Strobes presented while cycleEn is 0 have no effect.
- R3: With no strobe and no interrupt request, fetchAddr advances by 1 per instruction cycle and wraps from 0x1FFF to 0x0000.
- R4: intReq bit k (0 external, 1 timer 0 overflow, 2 timer 1 overflow, 3 peripheral, 4 real-time clock, 5 dialer I/O) loads vector 4*(k+1), that is 0x004 to 0x018. When several bits are set, the lowest set bit wins.
- R5: A lowWrite loads fetchAddr[7:0] with lowData and keeps fetchAddr[12:8].
- R6: jumpReq loads jumpTarget. retReq loads retAddr.
- R7: skipReq advances fetchAddr by 2, modulo 8192.
- R8: Precedence is interrupt, then return, then jump, then low-byte write, then skip, then increment.
- R9: After any load other than the increment, flush is 1 for exactly the following instruction cycle. After an increment it is 0.
- R10: lowRead always equals fetchAddr[7:0].
- R11: intTaken is 1 exactly when cycleEn is 1 and any intReq bit is set. In that cycle pushAddr equals the current fetchAddr, which is the next unexecuted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleEn | input | 1 | Instruction-cycle boundary enable |
| skipReq | input | 1 | Taken conditional skip |
| lowWrite | input | 1 | Write of the low address byte |
| lowData | input | 8 | Byte written to the low address byte |
| jumpReq | input | 1 | Jump or call taken |
| jumpTarget | input | 13 | Jump or call destination |
| retReq | input | 1 | Return from subroutine |
| retAddr | input | 13 | Top-of-stack return address |
| intReq | input | 6 | Interrupt requests, bit 0 highest precedence |
| fetchAddr | output | 13 | Program memory fetch address |
| flush | output | 1 | Discard prefetched word (dummy cycle) |
| lowRead | output | 8 | Readback of the low address byte |
| intTaken | output | 1 | Interrupt vector being loaded this cycle |
| pushAddr | output | 13 | Return address for the stack on interrupt entry |

## Verification
An interrupt request and a decoder strobe, such as a return, jump, low-byte write or skip, can arrive on the same instruction boundary. Two strobes can also coincide with each other. The bench sweeps all 64 request patterns while holding different strobes active, and it sweeps all 16 strobe combinations with no request. Each result is judged against an arithmetic model of the precedence order. The same steps also confirm that flush follows every redirect, and that pushAddr carries the pre-interrupt address.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int VEC_IDX_W = 3;

  typedef enum logic [2:0] {
    SRC_INC,
    SRC_SKIP,
    SRC_LOW,
    SRC_JUMP,
    SRC_RET,
    SRC_VEC
  } srcSel_e;

  typedef struct packed {
    srcSel_e              src;
    logic [VEC_IDX_W-1:0] vecIdx;
    logic                 redirect;
  } pcCtrl_t;
endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
#(
  parameter int INT_N = 6
) (
  input  logic             skipReq,
  input  logic             lowWrite,
  input  logic             jumpReq,
  input  logic             retReq,
  input  logic [INT_N-1:0] intReq,
  output pcCtrl_t          ctrl,
  output logic             intAny
);
  logic [VEC_IDX_W-1:0] idx;

  // lowest-numbered request wins: scan downward so it is written last
  always_comb begin
    idx = '0;
    for (int i = INT_N - 1; i >= 0; i--) begin
      if (intReq[i]) idx = VEC_IDX_W'(i);
    end
  end

  assign intAny = |intReq;

  always_comb begin
    ctrl.vecIdx = idx;
    if (intAny)        ctrl.src = SRC_VEC;
    else if (retReq)   ctrl.src = SRC_RET;
    else if (jumpReq)  ctrl.src = SRC_JUMP;
    else if (lowWrite) ctrl.src = SRC_LOW;
    else if (skipReq)  ctrl.src = SRC_SKIP;
    else               ctrl.src = SRC_INC;
    ctrl.redirect = (ctrl.src != SRC_INC);
  end
endmodule

// File: rtl/pc_seq_dp.sv
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 8,
  parameter int VEC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  pcCtrl_t           ctrl,
  input  logic [PAGE_W-1:0] lowData,
  input  logic [ADDR_W-1:0] jumpTarget,
  input  logic [ADDR_W-1:0] retAddr,
  output logic [ADDR_W-1:0] pc,
  output logic              flush
);
  logic [ADDR_W-1:0] nextPc;
  logic [ADDR_W-1:0] vecAddr;

  assign vecAddr = (ADDR_W'(ctrl.vecIdx) + ADDR_W'(1)) << VEC_SHIFT;

  always_comb begin
    unique case (ctrl.src)
      SRC_VEC:  nextPc = vecAddr;
      SRC_RET:  nextPc = retAddr;
      SRC_JUMP: nextPc = jumpTarget;
      SRC_LOW:  nextPc = {pc[ADDR_W-1:PAGE_W], lowData};
      SRC_SKIP: nextPc = pc + ADDR_W'(2);
      default:  nextPc = pc + ADDR_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      flush <= 1'b0;
    end else if (cycleEn) begin
      pc    <= nextPc;
      flush <= ctrl.redirect;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 8,
  parameter int INT_N  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  logic              skipReq,
  input  logic              lowWrite,
  input  logic [PAGE_W-1:0] lowData,
  input  logic              jumpReq,
  input  logic [ADDR_W-1:0] jumpTarget,
  input  logic              retReq,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [INT_N-1:0]  intReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              flush,
  output logic [PAGE_W-1:0] lowRead,
  output logic              intTaken,
  output logic [ADDR_W-1:0] pushAddr
);
  pcCtrl_t ctrl;
  logic    intAny;

  pc_seq_ctrl #(.INT_N(INT_N)) u_ctrl (
    .skipReq (skipReq),
    .lowWrite(lowWrite),
    .jumpReq (jumpReq),
    .retReq  (retReq),
    .intReq  (intReq),
    .ctrl    (ctrl),
    .intAny  (intAny)
  );

  pc_seq_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .VEC_SHIFT(2)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cycleEn   (cycleEn),
    .ctrl      (ctrl),
    .lowData   (lowData),
    .jumpTarget(jumpTarget),
    .retAddr   (retAddr),
    .pc        (fetchAddr),
    .flush     (flush)
  );

  assign lowRead  = fetchAddr[PAGE_W-1:0];
  assign intTaken = cycleEn & intAny;
  assign pushAddr = fetchAddr;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 8,
  parameter int INT_N  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycleEn,
  input logic              skipReq,
  input logic              lowWrite,
  input logic [PAGE_W-1:0] lowData,
  input logic              jumpReq,
  input logic [ADDR_W-1:0] jumpTarget,
  input logic              retReq,
  input logic [ADDR_W-1:0] retAddr,
  input logic [INT_N-1:0]  intReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              flush,
  input logic [PAGE_W-1:0] lowRead,
  input logic              intTaken,
  input logic [ADDR_W-1:0] pushAddr
);
  logic anyLoad;
  assign anyLoad = (intReq != '0) | retReq | jumpReq | lowWrite | skipReq;

  a_r2_hold_between_cycles: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEn |=> ($stable(fetchAddr) && $stable(flush)));

  a_r3_plain_increment: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEn && !anyLoad) |=> (fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1)) && !flush);

  a_r5_page_kept: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEn && lowWrite && !retReq && !jumpReq && intReq == '0)
      |=> (fetchAddr[ADDR_W-1:PAGE_W] == $past(fetchAddr[ADDR_W-1:PAGE_W]))
          && (fetchAddr[PAGE_W-1:0] == $past(lowData)));

  a_r6_return_load: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEn && retReq && intReq == '0) |=> fetchAddr == $past(retAddr));

  a_r9_flush_on_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEn && anyLoad) |=> flush);

  a_r10_low_readback: assert property (@(posedge clk) disable iff (!rstN)
    lowRead == fetchAddr[PAGE_W-1:0]);

  a_r11_push_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |-> (cycleEn && pushAddr == fetchAddr));
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .INT_N(INT_N)) u_chk (.*);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleEn = 1'b0;
  logic        skipReq = 1'b0, lowWrite = 1'b0, jumpReq = 1'b0, retReq = 1'b0;
  logic [7:0]  lowData = '0;
  logic [12:0] jumpTarget = '0, retAddr = '0;
  logic [5:0]  intReq = '0;
  logic [12:0] fetchAddr, pushAddr;
  logic        flush, intTaken;
  logic [7:0]  lowRead;

  int checks = 0;
  int errors = 0;
  logic [12:0] expPc = '0;

  always #4 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .skipReq(skipReq),
    .lowWrite(lowWrite), .lowData(lowData), .jumpReq(jumpReq),
    .jumpTarget(jumpTarget), .retReq(retReq), .retAddr(retAddr),
    .intReq(intReq), .fetchAddr(fetchAddr), .flush(flush),
    .lowRead(lowRead), .intTaken(intTaken), .pushAddr(pushAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] model(input logic [12:0] pc, input logic [5:0] irq,
      input logic r, input logic j, input logic l, input logic s,
      input logic [12:0] tgt, input logic [12:0] ra, input logic [7:0] ld);
    if (irq != 0) begin
      for (int k = 0; k < 6; k++) if (irq[k]) return 13'((k + 1) * 4);
    end
    if (r) return ra;
    if (j) return tgt;
    if (l) return {pc[12:8], ld};
    if (s) return 13'(pc + 2);
    return 13'(pc + 1);
  endfunction

  // one instruction cycle: enable on the first of four clocks
  task automatic step(input logic [5:0] irq, input logic r, input logic j, input logic l,
      input logic s, input logic [12:0] tgt, input logic [12:0] ra, input logic [7:0] ld,
      input string tag);
    logic [12:0] nxt;
    logic        expFl;
    logic [12:0] held;
    @(negedge clk);
    intReq = irq; retReq = r; jumpReq = j; lowWrite = l; skipReq = s;
    jumpTarget = tgt; retAddr = ra; lowData = ld; cycleEn = 1'b1;
    #1;
    check({"R11 intTaken ", tag}, 32'(intTaken), 32'(irq != 0));
    if (irq != 0) check({"R11 pushAddr ", tag}, 32'(pushAddr), 32'(expPc));
    nxt   = model(expPc, irq, r, j, l, s, tgt, ra, ld);
    expFl = (irq != 0) | r | j | l | s;
    @(negedge clk);
    cycleEn = 1'b0;
    // strobes held active while disabled must do nothing (R2)
    skipReq = 1'b1; jumpReq = 1'b1; intReq = 6'h3F;
    expPc = nxt;
    check({"R3-R8 fetchAddr ", tag}, 32'(fetchAddr), 32'(expPc));
    check({"R9 flush ", tag}, 32'(flush), 32'(expFl));
    check({"R10 lowRead ", tag}, 32'(lowRead), 32'(expPc[7:0]));
    held = fetchAddr;
    repeat (3) @(negedge clk);
    check({"R2 hold ", tag}, 32'({flush, fetchAddr}), 32'({expFl, held}));
    intReq = '0; skipReq = 1'b0; jumpReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 fetchAddr reset", 32'(fetchAddr), 32'h0);
    check("R1 flush reset", 32'(flush), 32'h0);
    check("R1 lowRead reset", 32'(lowRead), 32'h0);
    rstN = 1'b1;
    expPc = '0;

    // R3: plain increments
    for (int n = 0; n < 5; n++) step(6'h0, 0, 0, 0, 0, 13'h0, 13'h0, 8'h0, "R3 incr");
    // R3 wrap
    step(6'h0, 0, 1, 0, 0, 13'h1FFF, 13'h0, 8'h0, "R6 jump to top");
    step(6'h0, 0, 0, 0, 0, 13'h0, 13'h0, 8'h0, "R3 wrap");
    // R7 wraps
    step(6'h0, 0, 1, 0, 0, 13'h1FFE, 13'h0, 8'h0, "R6 jump");
    step(6'h0, 0, 0, 0, 1, 13'h0, 13'h0, 8'h0, "R7 skip wrap to 0");
    step(6'h0, 0, 1, 0, 0, 13'h1FFF, 13'h0, 8'h0, "R6 jump");
    step(6'h0, 0, 0, 0, 1, 13'h0, 13'h0, 8'h0, "R7 skip wrap to 1");
    // R5: page kept
    step(6'h0, 0, 1, 0, 0, 13'h1A37, 13'h0, 8'h0, "R6 jump page");
    step(6'h0, 0, 0, 1, 0, 13'h0, 13'h0, 8'hC4, "R5 low write");
    step(6'h0, 0, 0, 1, 0, 13'h0, 13'h0, 8'hFF, "R5 low write ff");
    step(6'h0, 0, 0, 0, 0, 13'h0, 13'h0, 8'h0, "R3 cross page");

    // R4/R8: all request patterns combined with rotating strobes
    for (int p = 0; p < 64; p++) begin
      logic [3:0] st;
      st = 4'(p);
      step(6'(p), st[3], st[2], st[1], st[0], 13'(p * 97 + 5), 13'(p * 131 + 3),
           8'(p * 7), "R4/R8 irq sweep");
    end
    // R6/R8: all strobe combinations without requests
    for (int c = 0; c < 16; c++) begin
      logic [3:0] st;
      st = 4'(c);
      step(6'h0, st[3], st[2], st[1], st[0], 13'(c * 311 + 17), 13'(c * 509 + 9),
           8'(c * 23 + 1), "R6/R8 strobe sweep");
      step(6'h0, 0, 0, 0, 0, 13'h0, 13'h0, 8'h0, "R9 flush clears");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule